// File: doc/BRIEF.md
# Per-Core Private Interrupt Configuration Registers

This block is a 32-bit register slave that holds the configuration and state of 32 private interrupts belonging to one processor core. For each interrupt it keeps a group bit, an enable bit, a pending latch, an active bit, an 8-bit priority, an edge/level selection, a group-modifier bit and non-secure access-control bits. Software reaches these through a simple request strobe with byte or word size. Each access carries a secure/non-secure attribute. A global security-disable input decides whether that attribute restricts anything.

With security enabled, a non-secure requester sees only the interrupts that the group register marks as non-secure. Reads of other interrupts return zero and writes to them are dropped. Non-secure priority accesses also see a halved, top-bit-forced view of the stored priority. Enable, pending and active state each have a set address and a clear address. The pending read merges the live input level of every level-triggered interrupt. Unmapped offsets and unsupported sizes read zero and change nothing, and they never report an error.

Top module: `irq_cfg_regs`

## Requirements
- R1: After reset every stored field is zero, except that interrupts 0-15 are fixed as edge-triggered and interrupts 16-31 reset as level-triggered. The sleep-request bit resets to zero.
- R2: Accesses are sampled on a clock edge when req_i is high. A write takes effect at that edge. A read raises rvalid_o for exactly one cycle after the request, with rdata_o valid in that cycle.
- R3: Word offsets 0x08/0x0C (enable), 0x10/0x14 (pending) and 0x18/0x1C (active) are set/clear pairs. Writing 1 to the first offset of a pair sets the bit, and writing 1 to the second clears it. Writing 0 has no effect. Both offsets read the current state.
- R4: When sec_dis_i=0 and secure_i=0, the data of the set/clear registers and of the two edge-configuration registers is ANDed with the group register (0x04) on both read and write.
- R5: When sec_dis_i=0, a non-secure access to the group register (0x04) reads zero and is ignored on write.
- R6: The group-modifier register (0x28) and the access-control register (0x2C) read zero and ignore writes unless secure_i=1 and sec_dis_i=0.
- R7: The priority array sits at 0x40-0x5F, one byte per interrupt. A byte access reaches one interrupt, with data in bits [7:0]. An aligned word access reaches four consecutive interrupts, with the lowest-numbered one in bits [7:0].
- R8: For a non-secure access with security enabled, a permitted priority reads as (stored<<1)&0xFF and is written as 0x80|(value>>1). The priority of a non-permitted interrupt reads zero and ignores writes.
- R9: A pending read returns the pending latch ORed with level_i for every level-triggered interrupt.
- R10: Register 0x20 reports the edge bits of interrupts 0-15, and register 0x24 reports those of interrupts 16-31. Interrupt n of a register's half appears at bit 2n+1, and all even bits read zero. Writes to 0x20 are ignored. In a write to 0x24, the odd bits set the edge bits of interrupts 16-31.
- R11: Register 0x00 has a writable sleep request at bit 0. Bit 1 (children asleep) reads equal to bit 0 immediately after the write. All other bits read zero.
- R12: Reserved offsets, misaligned word accesses, byte accesses outside the priority array and sizes other than byte (0) or word (2) read zero and have no side effect.
- R13: With sec_dis_i=1, a non-secure access has the same unmasked, unshifted view as a secure one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | 0 byte, 1 half, 2 word, 3 double (only 0 and 2 are supported) |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data |
| secure_i | input | 1 | Access is secure |
| sec_dis_i | input | 1 | Global security disable |
| level_i | input | 32 | Current input level per interrupt |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |

## Verification
The bench mixes secure and non-secure requesters against a group register that splits the interrupts. This shows whether masking is applied on both the write path and the read path of each set/clear pair. Priority traffic uses distinct byte values per lane, in both byte and word form and in both views, so that lane-order faults and shift-direction faults each give a different wrong value. The level-input pattern shows one line toggled from level to edge, which separates the stored latch from the merged line. A repeat of the non-secure accesses with security disabled confirms that the restriction is tied to the global input.

// File: rtl/irq_cfg_pkg.sv
package irq_cfg_pkg;
  localparam int unsigned OFF_WAKE    = 'h00;
  localparam int unsigned OFF_GROUP   = 'h04;
  localparam int unsigned OFF_SETEN   = 'h08;
  localparam int unsigned OFF_CLREN   = 'h0C;
  localparam int unsigned OFF_SETPEND = 'h10;
  localparam int unsigned OFF_CLRPEND = 'h14;
  localparam int unsigned OFF_SETACT  = 'h18;
  localparam int unsigned OFF_CLRACT  = 'h1C;
  localparam int unsigned OFF_CFG0    = 'h20;
  localparam int unsigned OFF_CFG1    = 'h24;
  localparam int unsigned OFF_GRPMOD  = 'h28;
  localparam int unsigned OFF_NSACC   = 'h2C;
  localparam int unsigned OFF_PRIO    = 'h40;

  localparam int unsigned WAKE_REQ_BIT    = 0;
  localparam int unsigned WAKE_ASLEEP_BIT = 1;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [3:0] {
    RG_NONE, RG_WAKE, RG_GROUP, RG_SETEN, RG_CLREN, RG_SETPEND, RG_CLRPEND,
    RG_SETACT, RG_CLRACT, RG_CFG0, RG_CFG1, RG_GRPMOD, RG_NSACC, RG_PRIO
  } reg_sel_e;
endpackage

// File: rtl/irq_cfg_dec.sv
module irq_cfg_dec
  import irq_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_IRQ = 32,
  localparam int unsigned IW     = $clog2(NUM_IRQ)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output reg_sel_e          sel_o,
  output logic              prio_word_o,
  output logic [IW-1:0]     prio_idx_o
);
  logic [ADDR_W-1:0] prio_off;
  logic              in_prio;

  assign prio_off   = addr_i - ADDR_W'(OFF_PRIO);
  assign in_prio    = (addr_i >= ADDR_W'(OFF_PRIO)) && (addr_i < ADDR_W'(OFF_PRIO + NUM_IRQ));
  assign prio_idx_o = prio_off[IW-1:0];

  always_comb begin
    sel_o       = RG_NONE;
    prio_word_o = 1'b0;
    if (size_i == SZ_WORD && addr_i[1:0] == 2'b00) begin
      prio_word_o = 1'b1;
      if (in_prio) sel_o = RG_PRIO;
      else begin
        case (addr_i)
          ADDR_W'(OFF_WAKE):    sel_o = RG_WAKE;
          ADDR_W'(OFF_GROUP):   sel_o = RG_GROUP;
          ADDR_W'(OFF_SETEN):   sel_o = RG_SETEN;
          ADDR_W'(OFF_CLREN):   sel_o = RG_CLREN;
          ADDR_W'(OFF_SETPEND): sel_o = RG_SETPEND;
          ADDR_W'(OFF_CLRPEND): sel_o = RG_CLRPEND;
          ADDR_W'(OFF_SETACT):  sel_o = RG_SETACT;
          ADDR_W'(OFF_CLRACT):  sel_o = RG_CLRACT;
          ADDR_W'(OFF_CFG0):    sel_o = RG_CFG0;
          ADDR_W'(OFF_CFG1):    sel_o = RG_CFG1;
          ADDR_W'(OFF_GRPMOD):  sel_o = RG_GRPMOD;
          ADDR_W'(OFF_NSACC):   sel_o = RG_NSACC;
          default:              sel_o = RG_NONE;
        endcase
      end
    end else if (size_i == SZ_BYTE && in_prio) begin
      sel_o = RG_PRIO;
    end
  end
endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank #(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IW     = $clog2(NUM_IRQ),
  localparam int unsigned LANES  = DATA_W / 8,
  localparam int unsigned LB     = $clog2(LANES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               word_i,
  input  logic [IW-1:0]      idx_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               ns_view_i,
  input  logic [NUM_IRQ-1:0] group_i,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [7:0] prio_q [NUM_IRQ];

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
    localparam logic [IW-1:0] GI = IW'(g);
    logic          hit;
    logic [LB-1:0] lane;
    logic [7:0]    wbyte;

    assign hit   = word_i ? (GI[IW-1:LB] == idx_i[IW-1:LB]) : (GI == idx_i);
    assign lane  = word_i ? GI[LB-1:0] : '0;
    assign wbyte = wdata_i[8*lane +: 8];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prio_q[g] <= '0;
      else if (wr_en_i && hit && (!ns_view_i || group_i[g]))
        prio_q[g] <= ns_view_i ? (8'h80 | (wbyte >> 1)) : wbyte;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [IW-1:0] ridx;
    logic [7:0]    rbyte;

    assign ridx  = word_i ? {idx_i[IW-1:LB], LB'(l)} : idx_i;
    assign rbyte = prio_q[ridx];

    always_comb begin
      if (!word_i && l != 0)                rdata_o[8*l +: 8] = '0;
      else if (ns_view_i && !group_i[ridx]) rdata_o[8*l +: 8] = '0;
      else if (ns_view_i)                   rdata_o[8*l +: 8] = {rbyte[6:0], 1'b0};
      else                                  rdata_o[8*l +: 8] = rbyte;
    end
  end
endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
  import irq_cfg_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  localparam int unsigned HALF   = NUM_IRQ / 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  reg_sel_e           sel_i,
  input  logic [NUM_IRQ-1:0] wdata_i,
  input  logic               ns_restricted_i,
  input  logic               cfg_priv_i,
  output logic [NUM_IRQ-1:0] mask_o,
  output logic [NUM_IRQ-1:0] group_o,
  output logic [NUM_IRQ-1:0] enable_o,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic [NUM_IRQ-1:0] active_o,
  output logic [NUM_IRQ-1:0] edge_o,
  output logic [NUM_IRQ-1:0] grpmod_o,
  output logic [NUM_IRQ-1:0] nsacc_o,
  output logic               sleep_o
);
  logic [HALF-1:0]    edge_hi_q, edge_hi_new, mask_hi;
  logic [NUM_IRQ-1:0] wmask;

  assign mask_o  = ns_restricted_i ? group_o : '1;
  assign wmask   = wdata_i & mask_o;
  assign mask_hi = mask_o[NUM_IRQ-1:HALF];
  assign edge_o  = {edge_hi_q, {HALF{1'b1}}};

  for (genvar n = 0; n < HALF; n++) begin : g_unpack
    assign edge_hi_new[n] = wdata_i[2*n+1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      group_o   <= '0;
      enable_o  <= '0;
      pend_o    <= '0;
      active_o  <= '0;
      edge_hi_q <= '0;
      grpmod_o  <= '0;
      nsacc_o   <= '0;
      sleep_o   <= 1'b0;
    end else if (wr_en_i) begin
      case (sel_i)
        RG_WAKE:    sleep_o  <= wdata_i[WAKE_REQ_BIT];
        RG_GROUP:   if (!ns_restricted_i) group_o <= wdata_i;
        RG_SETEN:   enable_o <= enable_o | wmask;
        RG_CLREN:   enable_o <= enable_o & ~wmask;
        RG_SETPEND: pend_o   <= pend_o | wmask;
        RG_CLRPEND: pend_o   <= pend_o & ~wmask;
        RG_SETACT:  active_o <= active_o | wmask;
        RG_CLRACT:  active_o <= active_o & ~wmask;
        RG_CFG1:    edge_hi_q <= (edge_hi_q & ~mask_hi) | (edge_hi_new & mask_hi);
        RG_GRPMOD:  if (cfg_priv_i) grpmod_o <= wdata_i;
        RG_NSACC:   if (cfg_priv_i) nsacc_o  <= wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned NUM_IRQ = DATA_W,
  localparam int unsigned HALF    = NUM_IRQ / 2,
  localparam int unsigned IW      = $clog2(NUM_IRQ)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              secure_i,
  input  logic              sec_dis_i,
  input  logic [DATA_W-1:0] level_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e           sel;
  logic               prio_word, ns_restricted, cfg_priv, wr_en, sleep;
  logic [IW-1:0]      prio_idx;
  logic [DATA_W-1:0]  prio_rdata, rd_mux;
  logic [NUM_IRQ-1:0] mask, group, enable, pend, active, edge_cfg, grpmod, nsacc, edge_m;
  logic [DATA_W-1:0]  cfg_lo, cfg_hi;

  assign ns_restricted = !secure_i && !sec_dis_i;
  assign cfg_priv      = secure_i && !sec_dis_i;
  assign wr_en         = req_i && we_i;

  irq_cfg_dec #(.ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ)) i_dec (
    .addr_i(addr_i), .size_i(size_i), .sel_o(sel),
    .prio_word_o(prio_word), .prio_idx_o(prio_idx)
  );

  irq_state_regs #(.NUM_IRQ(NUM_IRQ)) i_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .sel_i(sel),
    .wdata_i(wdata_i), .ns_restricted_i(ns_restricted), .cfg_priv_i(cfg_priv),
    .mask_o(mask), .group_o(group), .enable_o(enable), .pend_o(pend),
    .active_o(active), .edge_o(edge_cfg), .grpmod_o(grpmod), .nsacc_o(nsacc),
    .sleep_o(sleep)
  );

  irq_prio_bank #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) i_prio (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en && sel == RG_PRIO),
    .word_i(prio_word), .idx_i(prio_idx), .wdata_i(wdata_i),
    .ns_view_i(ns_restricted), .group_i(group), .rdata_o(prio_rdata)
  );

  assign edge_m = edge_cfg & mask;
  for (genvar n = 0; n < HALF; n++) begin : g_pack
    assign cfg_lo[2*n+1] = edge_m[n];
    assign cfg_lo[2*n]   = 1'b0;
    assign cfg_hi[2*n+1] = edge_m[HALF+n];
    assign cfg_hi[2*n]   = 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      RG_WAKE: begin
        rd_mux[WAKE_REQ_BIT]    = sleep;
        rd_mux[WAKE_ASLEEP_BIT] = sleep;
      end
      RG_GROUP:               rd_mux = ns_restricted ? '0 : group;
      RG_SETEN, RG_CLREN:     rd_mux = enable & mask;
      RG_SETPEND, RG_CLRPEND: rd_mux = (pend | (~edge_cfg & level_i)) & mask;
      RG_SETACT, RG_CLRACT:   rd_mux = active & mask;
      RG_CFG0:                rd_mux = cfg_lo;
      RG_CFG1:                rd_mux = cfg_hi;
      RG_GRPMOD:              rd_mux = cfg_priv ? grpmod : '0;
      RG_NSACC:               rd_mux = cfg_priv ? nsacc : '0;
      RG_PRIO:                rd_mux = prio_rdata;
      default:                rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= req_i && !we_i;
      if (req_i && !we_i) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_cfg_regs_chk.sv
module irq_cfg_regs_chk
  import irq_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [1:0]        size_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              secure_i,
  input logic              sec_dis_i,
  input logic              rvalid_o,
  input logic [DATA_W-1:0] rdata_o
);
  logic rd, ns_r, word_rd, in_prio;
  assign rd      = req_i && !we_i;
  assign ns_r    = !secure_i && !sec_dis_i;
  assign word_rd = rd && size_i == SZ_WORD && addr_i[1:0] == 2'b00;
  assign in_prio = addr_i >= ADDR_W'(OFF_PRIO) && addr_i < ADDR_W'(OFF_PRIO + DATA_W);

  a_r2_rvalid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_o);
  a_r2_no_stray_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !rvalid_o);
  a_r11_asleep_mirrors_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_rd && addr_i == ADDR_W'(OFF_WAKE)) |=>
      (rdata_o[WAKE_ASLEEP_BIT] == rdata_o[WAKE_REQ_BIT]) && ($countones(rdata_o) <= 2));
  a_r12_bad_size_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && size_i != SZ_BYTE && size_i != SZ_WORD) |=> rdata_o == '0);
  a_r12_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_rd && addr_i >= ADDR_W'(OFF_PRIO + DATA_W)) |=> rdata_o == '0);
  a_r5_group_ns_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_rd && ns_r && addr_i == ADDR_W'(OFF_GROUP)) |=> rdata_o == '0);
  a_r6_priv_regs_ns_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_rd && !(secure_i && !sec_dis_i) &&
     (addr_i == ADDR_W'(OFF_GRPMOD) || addr_i == ADDR_W'(OFF_NSACC))) |=> rdata_o == '0);
  a_r8_ns_prio_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_rd && ns_r && in_prio) |=>
      !rdata_o[0] && !rdata_o[8] && !rdata_o[16] && !rdata_o[24]);
endmodule

bind irq_cfg_regs irq_cfg_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .size_i(size_i),
  .addr_i(addr_i), .secure_i(secure_i), .sec_dis_i(sec_dis_i),
  .rvalid_o(rvalid_o), .rdata_o(rdata_o)
);

// File: tb/test_irq_cfg_regs.sv
module test_irq_cfg_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, secure_i = 1'b1, sec_dis_i = 1'b0;
  logic [1:0]  size_i = 2'd2;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, level_i = '0;
  logic        rvalid_o;
  logic [31:0] rdata_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam bit S = 1'b1, NS = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_cfg_regs i_irq_cfg_regs (.*);

  task automatic acc(input bit we, input logic [1:0] sz, input logic [7:0] a,
                     input logic [31:0] d, input bit sec);
    req_i = 1'b1; we_i = we; size_i = sz; addr_i = a; wdata_i = d; secure_i = sec;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit sec);
    acc(1'b1, 2'd2, a, d, sec);
  endtask

  task automatic rd(input logic [1:0] sz, input logic [7:0] a, input bit sec,
                    input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    acc(1'b0, sz, a, 32'h0, sec);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && rvalid_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected rvalid actual %h expected none", rdata_o);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata_o !== e) begin
          errors++;
          $display("FAIL %s actual %h expected %h", t, rdata_o, e);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (rvalid_o !== 1'b0 || rdata_o !== 32'h0) begin
      errors++;
      $display("FAIL R1 outputs in reset actual %b/%h expected 0/0", rvalid_o, rdata_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(2, 8'h00, S, 32'h0, "R1 wake");
    rd(2, 8'h04, S, 32'h0, "R1 group");
    rd(2, 8'h08, S, 32'h0, "R1 enable");
    rd(2, 8'h20, S, 32'hAAAAAAAA, "R1 cfg0 edge");
    rd(2, 8'h24, S, 32'h0, "R1 cfg1 level");
    rd(2, 8'h40, S, 32'h0, "R1 prio");

    // R5 group
    wr(8'h04, 32'h0000FF00, S);
    rd(2, 8'h04, S, 32'h0000FF00, "R5 secure group");
    wr(8'h04, 32'hFFFFFFFF, NS);
    rd(2, 8'h04, S, 32'h0000FF00, "R5 ns write ignored");
    rd(2, 8'h04, NS, 32'h0, "R5 ns read zero");

    // R3 / R4 enable
    wr(8'h08, 32'h00000011, S);
    wr(8'h08, 32'hFFFFFFFF, NS);
    rd(2, 8'h0C, S, 32'h0000FF11, "R3 R4 set masked");
    rd(2, 8'h08, NS, 32'h0000FF00, "R4 ns read masked");
    wr(8'h0C, 32'hFFFFFFFF, NS);
    rd(2, 8'h08, S, 32'h00000011, "R4 ns clear masked");
    wr(8'h0C, 32'h00000001, S);
    rd(2, 8'h08, S, 32'h00000010, "R3 clear enable");

    // R9 / R10 pending and config
    level_i = 32'h00030000;
    wr(8'h10, 32'h80000001, S);
    rd(2, 8'h10, S, 32'h80030001, "R9 pend or level");
    wr(8'h24, 32'h00000002, S);
    rd(2, 8'h24, S, 32'h00000002, "R10 cfg1 write");
    rd(2, 8'h10, S, 32'h80020001, "R9 edge line excluded");
    wr(8'h20, 32'h00000000, S);
    rd(2, 8'h20, S, 32'hAAAAAAAA, "R10 cfg0 ignores write");
    rd(2, 8'h20, NS, 32'hAAAA0000, "R4 R10 ns cfg0 masked");
    wr(8'h24, 32'hFFFFFFFF, NS);
    rd(2, 8'h24, S, 32'h00000002, "R4 ns cfg1 write masked");
    wr(8'h14, 32'h80000000, S);
    rd(2, 8'h14, S, 32'h00020001, "R3 clear pending");

    // R3 active
    wr(8'h18, 32'h000000F0, S);
    rd(2, 8'h1C, S, 32'h000000F0, "R3 set active");
    wr(8'h1C, 32'h00000030, S);
    rd(2, 8'h18, S, 32'h000000C0, "R3 clear active");

    // R7 / R8 priority
    wr(8'h40, 32'h44332211, S);
    rd(0, 8'h42, S, 32'h00000033, "R7 byte read lane");
    rd(2, 8'h40, S, 32'h44332211, "R7 word order");
    acc(1'b1, 2'd0, 8'h41, 32'h000000AB, S);
    rd(2, 8'h40, S, 32'h4433AB11, "R7 byte write");
    wr(8'h48, 32'h40302010, NS);
    rd(2, 8'h48, S, 32'hA0989088, "R8 ns write stored");
    rd(2, 8'h48, NS, 32'h40302010, "R8 ns read view");
    acc(1'b1, 2'd0, 8'h40, 32'h000000FF, NS);
    rd(0, 8'h40, S, 32'h00000011, "R8 ns write denied");
    rd(2, 8'h40, NS, 32'h0, "R8 ns read denied");

    // R6
    wr(8'h28, 32'h00001234, S);
    rd(2, 8'h28, S, 32'h00001234, "R6 grpmod secure");
    wr(8'h28, 32'h0000FFFF, NS);
    rd(2, 8'h28, S, 32'h00001234, "R6 grpmod ns ignored");
    rd(2, 8'h28, NS, 32'h0, "R6 grpmod ns zero");
    wr(8'h2C, 32'h0000A5A5, S);
    rd(2, 8'h2C, S, 32'h0000A5A5, "R6 access ctl secure");

    // R11 wake
    wr(8'h00, 32'hFFFFFFFF, S);
    rd(2, 8'h00, S, 32'h00000003, "R11 sleep set");
    wr(8'h00, 32'h0, S);
    rd(2, 8'h00, S, 32'h0, "R11 sleep clear");
    wr(8'h00, 32'h00000002, S);
    rd(2, 8'h00, S, 32'h0, "R11 asleep not writable");

    // R12 reserved and bad sizes
    wr(8'h30, 32'hFFFFFFFF, S);
    rd(2, 8'h30, S, 32'h0, "R12 reserved read");
    acc(1'b1, 2'd1, 8'h08, 32'hFFFFFFFF, S);
    rd(2, 8'h08, S, 32'h00000010, "R12 half write no effect");
    rd(1, 8'h08, S, 32'h0, "R12 half read zero");
    rd(0, 8'h08, S, 32'h0, "R12 byte outside prio");
    rd(2, 8'h41, S, 32'h0, "R12 misaligned word");
    acc(1'b1, 2'd3, 8'h18, 32'hFFFFFFFF, S);
    rd(2, 8'h18, S, 32'h000000C0, "R12 dword write no effect");

    // R13 security disabled
    sec_dis_i = 1'b1;
    rd(2, 8'h04, NS, 32'h0000FF00, "R13 ns group visible");
    wr(8'h08, 32'h00000001, NS);
    rd(2, 8'h08, NS, 32'h00000011, "R13 ns set unmasked");
    rd(0, 8'h40, NS, 32'h00000011, "R13 ns prio unshifted");
    rd(2, 8'h28, S, 32'h0, "R6 grpmod with security off");

    repeat (4) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 missing %0d read responses actual 0 expected %0d", exp_q.size(), exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule